// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is a register file for a processor that keeps procedure frames in registers instead of memory. The windowed storage is a ring of equal windows. Each window exposes a parameter area, a local area and a temporary area. The temporary area of one window is the same physical storage as the parameter area of the window after it in the ring. A caller writes its arguments into its temporaries, and after the call the callee finds them in its parameters, with no copy. A bank of global registers is also visible, and the window pointer does not affect it.

Instructions give a 5-bit register specifier that is relative to the current window. The block maps each specifier to a physical entry for two combinational read ports and one write port. A call pulse moves the current window pointer one step forward, and a return pulse moves it one step back. At most one fewer window than the ring size can be resident. A call made while the ring is full raises an overflow trap and streams the oldest window out through a spill handshake port. A return from the last resident window raises an underflow trap and takes the caller's window back in through a fill handshake port. The call or return that caused the trap takes effect only when its transfer is complete. A saved-window pointer marks the window most recently moved out to memory.

Top module: `winreg_file`

## Requirements
- R1: After reset the current window pointer is 0, the saved-window pointer is 7, both traps are low, the spill valid output is low and the fill ready output is low.
- R2: Specifier bits [4:3] select the area: 0 global, 1 parameter, 2 local, 3 temporary. Bits [2:0] give the index within the area. A global access reaches the same register from every window. A write becomes visible on the read ports from the next cycle on, and the window pointer in force at the clock edge selects the entry.
- R3: The temporary register with index i of window w is the same storage as the parameter register with index i of window w+1 (mod 8), in both directions.
- R4: With no trap pending, a call moves the current window pointer to +1 (mod 8) and a return moves it to -1 (mod 8). This holds while fewer than 7 windows are resident for a call, or more than 1 for a return.
- R5: A call while 7 windows are resident raises the overflow trap and asserts spill valid. The spill window output is (current+2) mod 8, which is the oldest resident window. Beat k (0..15) carries entry k of that window: beats 0-7 are its parameter area and beats 8-15 are its local area. The current window pointer does not move while the trap is up.
- R6: The beat after the 16th accepted spill beat drops the overflow trap. In the same step the current window pointer advances by one and the saved-window pointer advances by one, onto the spilled window.
- R7: While spill valid is high and spill ready is low, spill valid stays high and the beat index holds.
- R8: A return while only one window is resident raises the underflow trap and asserts fill ready. The fill window equals the saved-window pointer, which is current-1 (mod 8). Each accepted beat k writes fill data into entry k of that window, with the same layout as R5. After beat 15 the trap drops and the current window pointer moves back by one, onto the refilled window.
- R9: While either trap is up, the call, return and write inputs are ignored.
- R10: A call and a return asserted in the same cycle are both ignored.
- R11: A read of the entry being written in the same cycle returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_i | input | 1 | Procedure call pulse |
| ret_i | input | 1 | Procedure return pulse |
| ra_spec_i | input | 5 | Read port A register specifier |
| ra_data_o | output | 32 | Read port A data |
| rb_spec_i | input | 5 | Read port B register specifier |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wspec_i | input | 5 | Write register specifier |
| wdata_i | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved-window pointer (most recently spilled window) |
| ovf_trap_o | output | 1 | Overflow trap, high while spilling |
| unf_trap_o | output | 1 | Underflow trap, high while filling |
| spill_valid_o | output | 1 | Spill beat available |
| spill_ready_i | input | 1 | Memory side accepts spill beat |
| spill_win_o | output | 3 | Window being spilled |
| spill_idx_o | output | 4 | Entry index of current spill beat |
| spill_data_o | output | 32 | Spill beat data |
| fill_ready_o | output | 1 | Block accepts fill beat |
| fill_valid_i | input | 1 | Fill beat available |
| fill_win_o | output | 3 | Window being filled |
| fill_idx_o | output | 4 | Entry index of current fill beat |
| fill_data_i | input | 32 | Fill beat data |

## Verification
The assertions take for granted that the memory side follows the handshakes: spill ready is honoured only while spill valid is up, and fill data is presented only against fill ready. They also assume that software never returns below the outermost frame, so every fill requests a window that was spilled earlier. The stimulus keeps a stack of every spilled beat and answers each fill from its top 16 entries, so a fill is never requested with nothing saved. Spill ready and fill valid drop on a fixed cycle pattern to produce stalls, and call, return and write pulses are applied during traps only to check that they are ignored.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  // Area code carried in the two upper specifier bits.
  typedef enum logic [1:0] {
    AR_GLB = 2'd0,
    AR_PAR = 2'd1,
    AR_LOC = 2'd2,
    AR_TMP = 2'd3
  } area_e;

  // Controller state.
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } wst_e;

endpackage

// File: rtl/wrf_rst_sync.sv
module wrf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/wrf_map.sv
module wrf_map #(
  parameter  int NWIN  = 8,
  parameter  int AREA  = 8,
  localparam int WW    = $clog2(NWIN),
  localparam int IW    = $clog2(AREA),
  localparam int SPW   = IW + 2,
  localparam int DEPTH = AREA + NWIN * 2 * AREA,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic [WW-1:0]  cwp_i,
  input  logic [SPW-1:0] spec_i,
  output logic [PW-1:0]  phys_o
);
  import wrf_pkg::*;

  area_e          area;
  logic [IW-1:0]  idx;
  logic [WW-1:0]  slot;
  logic           upper_half;

  assign area = area_e'(spec_i[SPW-1 -: 2]);
  assign idx  = spec_i[IW-1:0];

  // Temporaries live in the parameter half of the next slot.
  always_comb begin
    slot       = cwp_i;
    upper_half = 1'b0;
    case (area)
      AR_LOC: upper_half = 1'b1;
      AR_TMP: slot       = cwp_i + WW'(1);
      default: ;
    endcase
  end

  always_comb begin
    if (area == AR_GLB) begin
      phys_o = PW'(idx);
    end else begin
      phys_o = PW'(AREA) + PW'({slot, upper_half, idx});
    end
  end

endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 136,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [AW-1:0]           wa_i,
  input  logic [DW-1:0]           wd_i,
  input  logic [NRD-1:0][AW-1:0]  ra_i,
  output logic [NRD-1:0][DW-1:0]  rd_o
);

  logic [DW-1:0] mem [DEPTH];

  // Storage array: no reset, contents defined by software.
  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[wa_i] <= wd_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_o[g] = mem[ra_i[g]];
  end

endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
  parameter  int NWIN = 8,
  parameter  int AREA = 8,
  localparam int WW   = $clog2(NWIN),
  localparam int BW   = $clog2(2 * AREA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          spill_ready_i,
  input  logic          fill_valid_i,
  output logic [WW-1:0] cwp_o,
  output logic [WW-1:0] swp_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          run_o,
  output logic          spill_valid_o,
  output logic [WW-1:0] spill_win_o,
  output logic          fill_ready_o,
  output logic          fill_we_o,
  output logic [WW-1:0] fill_win_o,
  output logic [BW-1:0] beat_o
);
  import wrf_pkg::*;

  localparam logic [WW-1:0] FULL = WW'(NWIN - 1);
  localparam logic [BW-1:0] LAST = BW'(2 * AREA - 1);

  wst_e          st_q, st_d;
  logic [WW-1:0] cwp_q, cwp_d;
  logic [WW-1:0] nres_q, nres_d;
  logic [BW-1:0] beat_q, beat_d;
  logic          st_en, cwp_en, nres_en, beat_en;
  logic          do_call, do_ret, spill_acc, fill_acc;

  assign do_call   = call_i && !ret_i;
  assign do_ret    = ret_i && !call_i;
  assign spill_acc = (st_q == ST_SPILL) && spill_ready_i;
  assign fill_acc  = (st_q == ST_FILL) && fill_valid_i;

  // Next-state logic.
  always_comb begin
    st_d    = st_q;
    cwp_d   = cwp_q;
    nres_d  = nres_q;
    beat_d  = beat_q;
    st_en   = 1'b0;
    cwp_en  = 1'b0;
    nres_en = 1'b0;
    beat_en = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (do_call) begin
          if (nres_q == FULL) begin
            st_d    = ST_SPILL;
            st_en   = 1'b1;
            beat_d  = '0;
            beat_en = 1'b1;
          end else begin
            cwp_d   = cwp_q + WW'(1);
            cwp_en  = 1'b1;
            nres_d  = nres_q + WW'(1);
            nres_en = 1'b1;
          end
        end else if (do_ret) begin
          if (nres_q == WW'(1)) begin
            st_d    = ST_FILL;
            st_en   = 1'b1;
            beat_d  = '0;
            beat_en = 1'b1;
          end else begin
            cwp_d   = cwp_q - WW'(1);
            cwp_en  = 1'b1;
            nres_d  = nres_q - WW'(1);
            nres_en = 1'b1;
          end
        end
      end
      ST_SPILL: begin
        if (spill_acc) begin
          beat_d  = beat_q + BW'(1);
          beat_en = 1'b1;
          if (beat_q == LAST) begin
            st_d   = ST_RUN;
            st_en  = 1'b1;
            cwp_d  = cwp_q + WW'(1);
            cwp_en = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (fill_acc) begin
          beat_d  = beat_q + BW'(1);
          beat_en = 1'b1;
          if (beat_q == LAST) begin
            st_d   = ST_RUN;
            st_en  = 1'b1;
            cwp_d  = cwp_q - WW'(1);
            cwp_en = 1'b1;
          end
        end
      end
      default: begin
        st_d  = ST_RUN;
        st_en = 1'b1;
      end
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      cwp_q  <= '0;
      nres_q <= WW'(1);
      beat_q <= '0;
    end else begin
      if (st_en)   st_q   <= st_d;
      if (cwp_en)  cwp_q  <= cwp_d;
      if (nres_en) nres_q <= nres_d;
      if (beat_en) beat_q <= beat_d;
    end
  end

  assign cwp_o         = cwp_q;
  assign swp_o         = cwp_q - nres_q;
  assign ovf_o         = (st_q == ST_SPILL);
  assign unf_o         = (st_q == ST_FILL);
  assign run_o         = (st_q == ST_RUN);
  assign spill_valid_o = ovf_o;
  assign spill_win_o   = cwp_q + WW'(2);
  assign fill_ready_o  = unf_o;
  assign fill_we_o     = fill_acc;
  assign fill_win_o    = cwp_q - WW'(1);
  assign beat_o        = beat_q;

  AST_CWP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cwp_q) |-> (cwp_q == $past(cwp_q) + WW'(1)) || (cwp_q == $past(cwp_q) - WW'(1))); // R4

  AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    nres_q != '0); // R4

  AST_TRAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o || unf_o) && $past(ovf_o || unf_o) |-> $stable(cwp_q)); // R5

  AST_SPILL_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> spill_win_o == swp_o + WW'(1)); // R5

  AST_SWP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_o) |-> swp_o == $past(swp_o) + WW'(1)); // R6

  AST_SPILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid_o && !spill_ready_i |=> spill_valid_o && $stable(beat_q)); // R7

  AST_FILL_AT_SWP: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> fill_win_o == swp_o); // R8

  AST_TRAP_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !spill_ready_i |=> $stable(cwp_q) && ovf_o); // R9

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter  int NWIN  = 8,
  parameter  int AREA  = 8,
  parameter  int DW    = 32,
  localparam int WW    = $clog2(NWIN),
  localparam int IW    = $clog2(AREA),
  localparam int SPW   = IW + 2,
  localparam int BW    = IW + 1,
  localparam int DEPTH = AREA + NWIN * 2 * AREA,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic [SPW-1:0] ra_spec_i,
  output logic [DW-1:0]  ra_data_o,
  input  logic [SPW-1:0] rb_spec_i,
  output logic [DW-1:0]  rb_data_o,
  input  logic           we_i,
  input  logic [SPW-1:0] wspec_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [WW-1:0]  cwp_o,
  output logic [WW-1:0]  swp_o,
  output logic           ovf_trap_o,
  output logic           unf_trap_o,
  output logic           spill_valid_o,
  input  logic           spill_ready_i,
  output logic [WW-1:0]  spill_win_o,
  output logic [BW-1:0]  spill_idx_o,
  output logic [DW-1:0]  spill_data_o,
  output logic           fill_ready_o,
  input  logic           fill_valid_i,
  output logic [WW-1:0]  fill_win_o,
  output logic [BW-1:0]  fill_idx_o,
  input  logic [DW-1:0]  fill_data_i
);

  localparam int NMAP = 3;   // read A, read B, write
  localparam int NRD  = 3;   // read A, read B, spill

  logic                  rst_sync_n;
  logic                  run;
  logic                  fill_we;
  logic [BW-1:0]         beat;
  logic [WW-1:0]         cwp;
  logic [NMAP-1:0][SPW-1:0] spec_v;
  logic [NMAP-1:0][PW-1:0]  phys_v;
  logic [NRD-1:0][PW-1:0]   rd_addr;
  logic [NRD-1:0][DW-1:0]   rd_data;
  logic [PW-1:0]         spill_addr;
  logic [PW-1:0]         fill_addr;
  logic                  st_we;
  logic [PW-1:0]         st_wa;
  logic [DW-1:0]         st_wd;

  wrf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wrf_ctrl #(.NWIN(NWIN), .AREA(AREA)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .call_i        (call_i),
    .ret_i         (ret_i),
    .spill_ready_i (spill_ready_i),
    .fill_valid_i  (fill_valid_i),
    .cwp_o         (cwp),
    .swp_o         (swp_o),
    .ovf_o         (ovf_trap_o),
    .unf_o         (unf_trap_o),
    .run_o         (run),
    .spill_valid_o (spill_valid_o),
    .spill_win_o   (spill_win_o),
    .fill_ready_o  (fill_ready_o),
    .fill_we_o     (fill_we),
    .fill_win_o    (fill_win_o),
    .beat_o        (beat)
  );

  assign spec_v[0] = ra_spec_i;
  assign spec_v[1] = rb_spec_i;
  assign spec_v[2] = wspec_i;

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    wrf_map #(.NWIN(NWIN), .AREA(AREA)) u_map (
      .cwp_i  (cwp),
      .spec_i (spec_v[g]),
      .phys_o (phys_v[g])
    );
  end

  // Whole-window transfers address a slot's parameter and local halves directly.
  assign spill_addr = PW'(AREA) + PW'({spill_win_o, beat});
  assign fill_addr  = PW'(AREA) + PW'({fill_win_o, beat});

  assign rd_addr[0] = phys_v[0];
  assign rd_addr[1] = phys_v[1];
  assign rd_addr[2] = spill_addr;

  // Fill beats own the write port; user writes only outside traps.
  assign st_we = fill_we || (we_i && run);
  assign st_wa = fill_we ? fill_addr   : phys_v[2];
  assign st_wd = fill_we ? fill_data_i : wdata_i;

  wrf_store #(.DW(DW), .DEPTH(DEPTH), .NRD(NRD)) u_store (
    .clk  (clk),
    .we_i (st_we),
    .wa_i (st_wa),
    .wd_i (st_wd),
    .ra_i (rd_addr),
    .rd_o (rd_data)
  );

  assign ra_data_o    = rd_data[0];
  assign rb_data_o    = rd_data[1];
  assign spill_data_o = rd_data[2];
  assign spill_idx_o  = beat;
  assign fill_idx_o   = beat;
  assign cwp_o        = cwp;

  AST_NO_USER_WRITE_IN_TRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_trap_o || unf_trap_o) && st_we |-> fill_we && st_wa == fill_addr); // R9

endmodule

// File: tb/winreg_file_tb.sv
module winreg_file_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_i, ret_i, we_i;
  logic [4:0]  ra_spec_i, rb_spec_i, wspec_i;
  logic [31:0] wdata_i, ra_data_o, rb_data_o;
  logic [2:0]  cwp_o, swp_o, spill_win_o, fill_win_o;
  logic        ovf_trap_o, unf_trap_o, spill_valid_o, spill_ready_i;
  logic [3:0]  spill_idx_o, fill_idx_o;
  logic [31:0] spill_data_o, fill_data_i;
  logic        fill_ready_o, fill_valid_i;

  always #5 clk = ~clk;

  winreg_file dut_i (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .ra_spec_i(ra_spec_i), .ra_data_o(ra_data_o),
    .rb_spec_i(rb_spec_i), .rb_data_o(rb_data_o),
    .we_i(we_i), .wspec_i(wspec_i), .wdata_i(wdata_i),
    .cwp_o(cwp_o), .swp_o(swp_o), .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o),
    .spill_valid_o(spill_valid_o), .spill_ready_i(spill_ready_i),
    .spill_win_o(spill_win_o), .spill_idx_o(spill_idx_o), .spill_data_o(spill_data_o),
    .fill_ready_o(fill_ready_o), .fill_valid_i(fill_valid_i),
    .fill_win_o(fill_win_o), .fill_idx_o(fill_idx_o), .fill_data_i(fill_data_i)
  );

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  // Behavioural reference: per-window entry lists, globals, a memory stack.
  int          m_cwp, m_nres, m_mode, m_beat;
  logic [31:0] m_g [8];
  logic [31:0] m_w [8][16];
  logic [31:0] stk [$];
  bit          chk_rd  = 1'b0;
  bit          auto_ra = 1'b1;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(logic [4:0] s);
    case (s[4:3])
      2'd0:    return m_g[s[2:0]];
      2'd1:    return m_w[m_cwp][s[2:0]];
      2'd2:    return m_w[m_cwp][8 + s[2:0]];
      default: return m_w[(m_cwp + 1) % 8][s[2:0]];
    endcase
  endfunction

  function automatic string rtag(logic [4:0] s);
    return (s[4:3] == 2'd3) ? "R3" : "R2";
  endfunction

  task automatic compare();
    chk("R4", "cwp", 32'(cwp_o), 32'(m_cwp));
    chk("R6", "swp", 32'(swp_o), 32'((m_cwp - m_nres + 8) % 8));
    chk("R5", "ovf_trap", 32'(ovf_trap_o), 32'(m_mode == 1));
    chk("R5", "spill_valid", 32'(spill_valid_o), 32'(m_mode == 1));
    chk("R8", "unf_trap", 32'(unf_trap_o), 32'(m_mode == 2));
    chk("R8", "fill_ready", 32'(fill_ready_o), 32'(m_mode == 2));
    if (m_mode == 1) begin
      chk("R5", "spill_win", 32'(spill_win_o), 32'((m_cwp + 2) % 8));
      chk("R7", "spill_idx", 32'(spill_idx_o), 32'(m_beat));
      chk("R5", "spill_data", spill_data_o, m_w[(m_cwp + 2) % 8][m_beat]);
    end
    if (m_mode == 2) begin
      chk("R8", "fill_win", 32'(fill_win_o), 32'((m_cwp + 7) % 8));
      chk("R8", "fill_idx", 32'(fill_idx_o), 32'(m_beat));
    end
    if (chk_rd) begin
      chk(rtag(ra_spec_i), "ra_data", ra_data_o, mread(ra_spec_i));
      chk(rtag(rb_spec_i), "rb_data", rb_data_o, mread(rb_spec_i));
    end
  endtask

  task automatic model_update();
    case (m_mode)
      0: begin
        if (we_i) begin
          case (wspec_i[4:3])
            2'd0: m_g[wspec_i[2:0]] = wdata_i;
            2'd1: m_w[m_cwp][wspec_i[2:0]] = wdata_i;
            2'd2: m_w[m_cwp][8 + wspec_i[2:0]] = wdata_i;
            default: m_w[(m_cwp + 1) % 8][wspec_i[2:0]] = wdata_i;
          endcase
        end
        if (call_i && !ret_i) begin
          if (m_nres == 7) begin m_mode = 1; m_beat = 0; end
          else begin m_cwp = (m_cwp + 1) % 8; m_nres++; end
        end else if (ret_i && !call_i) begin
          if (m_nres == 1) begin m_mode = 2; m_beat = 0; end
          else begin m_cwp = (m_cwp + 7) % 8; m_nres--; end
        end
      end
      1: begin
        if (spill_ready_i) begin
          stk.push_back(m_w[(m_cwp + 2) % 8][m_beat]);
          m_beat++;
          if (m_beat == 16) begin m_mode = 0; m_cwp = (m_cwp + 1) % 8; end
        end
      end
      default: begin
        if (fill_valid_i) begin
          m_w[(m_cwp + 7) % 8][m_beat] = fill_data_i;
          m_beat++;
          if (m_beat == 16) begin
            repeat (16) void'(stk.pop_back());
            m_mode = 0;
            m_cwp  = (m_cwp + 7) % 8;
          end
        end
      end
    endcase
  endtask

  task automatic tick();
    spill_ready_i = ((cyc % 3) != 1);
    fill_valid_i  = ((cyc % 4) != 2);
    if (m_mode == 2 && stk.size() >= 16) fill_data_i = stk[stk.size() - 16 + m_beat];
    else                                 fill_data_i = 32'hDEAD_0000 | 32'(cyc);
    rb_spec_i = 5'(cyc * 7 + 3);
    if (auto_ra) ra_spec_i = 5'(cyc * 5 + 1);
    #1;
    compare();
    @(posedge clk);
    model_update();
    cyc++;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (m_mode != 0) tick();
  endtask

  task automatic do_call();
    call_i = 1'b1; tick(); call_i = 1'b0; wait_idle();
  endtask

  task automatic do_ret();
    ret_i = 1'b1; tick(); ret_i = 1'b0; wait_idle();
  endtask

  task automatic do_wr(logic [4:0] s, logic [31:0] d);
    we_i = 1'b1; wspec_i = s; wdata_i = d; tick(); we_i = 1'b0;
  endtask

  task automatic xchk(logic [4:0] s, logic [31:0] exp, string tag, string what);
    ra_spec_i = s;
    #1;
    chk(tag, what, ra_data_o, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v_glb, v_tmp, v_par, v_loc, v_new;
    int          c0;
    rst_n = 1'b0; call_i = 1'b0; ret_i = 1'b0; we_i = 1'b0;
    wspec_i = '0; wdata_i = '0; ra_spec_i = '0; rb_spec_i = '0;
    spill_ready_i = 1'b0; fill_valid_i = 1'b0; fill_data_i = '0;
    m_cwp = 0; m_nres = 1; m_mode = 0; m_beat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", "cwp", 32'(cwp_o), 32'd0);
    chk("R1", "swp", 32'(swp_o), 32'd7);
    chk("R1", "traps", 32'({ovf_trap_o, unf_trap_o}), 32'd0);
    chk("R1", "spill_valid", 32'(spill_valid_o), 32'd0);
    chk("R1", "fill_ready", 32'(fill_ready_o), 32'd0);

    // Fill every entry; the seventh call overflows and spills window 0 (R5, R6, R7).
    for (int g = 0; g < 8; g++) do_wr(5'(g), 32'h6100_0000 | 32'(g));
    for (int w = 0; w < 8; w++) begin
      for (int k = 8; k < 24; k++) do_wr(5'(k), {8'(w), 8'(k), 16'h1234});
      if (w < 7) do_call();
    end
    chk_rd = 1'b1;

    // R2: a global written in one window reads back unchanged in the next.
    v_glb = 32'hA11C_0003;
    do_wr(5'd3, v_glb);
    do_call();
    xchk(5'd3, v_glb, "R2", "global after call");

    // R3: temporaries of the caller are the parameters of the callee, both ways.
    v_tmp = 32'h7E30_0002;
    do_wr(5'd26, v_tmp);
    do_call();
    xchk(5'd10, v_tmp, "R3", "callee param sees caller temp");
    v_par = 32'h9A4A_0003;
    do_wr(5'd11, v_par);
    do_ret();
    xchk(5'd27, v_par, "R3", "caller temp sees callee param");

    // Deep calls with a marked local in the first window; most calls overflow.
    v_loc = 32'h10CA_1001;
    do_wr(5'd17, v_loc);
    for (int i = 0; i < 10; i++) begin
      do_call();
      do_wr(5'(16 + (i % 8)), 32'h5000_0000 | 32'(i));
    end

    // R9: call, return and write during an overflow trap are ignored.
    c0 = m_cwp;
    call_i = 1'b1; tick(); call_i = 1'b0;
    chk("R9", "overflow raised", 32'(ovf_trap_o), 32'd1);
    call_i = 1'b1; we_i = 1'b1; wspec_i = 5'd5; wdata_i = 32'hBAD0_0005;
    tick(); tick();
    call_i = 1'b0; ret_i = 1'b1; tick(); ret_i = 1'b0; we_i = 1'b0;
    wait_idle();
    chk("R9", "single advance", 32'(cwp_o), 32'((c0 + 1) % 8));
    xchk(5'd5, 32'h6100_0005, "R9", "global untouched");

    // R8: returns drain resident windows and refill spilled ones.
    for (int i = 0; i < 16; i++) begin
      do_ret();
      if (i == 10) xchk(5'd17, v_loc, "R8", "refilled local");
    end

    // R10: simultaneous call and return do nothing.
    c0 = m_cwp;
    call_i = 1'b1; ret_i = 1'b1; tick(); call_i = 1'b0; ret_i = 1'b0;
    chk("R10", "cwp unchanged", 32'(cwp_o), 32'(c0));
    chk("R10", "no trap", 32'({ovf_trap_o, unf_trap_o}), 32'd0);

    // R11: same-cycle read of a written entry returns old data.
    auto_ra = 1'b0;
    v_new = 32'hC0FF_EE11;
    ra_spec_i = 5'd20;
    we_i = 1'b1; wspec_i = 5'd20; wdata_i = v_new;
    #1;
    chk("R11", "read old", ra_data_o, mread(5'd20));
    tick();
    we_i = 1'b0;
    xchk(5'd20, v_new, "R11", "read new next cycle");
    auto_ra = 1'b1;
    tick();

    finish_run();
  end

endmodule